// File: doc/BRIEF.md
# Key-Protected Pad Configuration Register Bank

This block is a memory-mapped bank of 32-bit configuration words, one per pad, placed behind a write lock. A system bus reaches it through a simple single-cycle port: byte address, write enable, write data, and read data that is available combinationally. Every stored word is driven continuously on a wide output. The pad multiplexing and pad drivers downstream use these words. Bits 3:0 of a word carry the function number, bits 9:8 the pull setting (0 none, 1 up, 3 down), and bits 11:10 the drive strength code (0..3 for 4, 6, 8 and 12 mA). The bank stores all 32 bits without interpreting them.

Writes to the pad words only take effect while the bank is open. To open or close the bank, software writes a key into the protect register at byte offset 0x400. The key is the protect register's own full bus address, which is the bank base plus 0x400. Bit 0 of the written value selects the new state: 1 opens the bank and 0 closes it. A chip normally has two instances, one per selection level, and each has its own lock. The second-level instance is built with small source-select registers placed directly after the protect register, at 0x404 and 0x408. These are 3 bits wide and sit behind the same lock.

Top module: `cfgbank_top`

## Requirements
- R1: After reset the bank is closed, every pad word and every source-select register reads zero, and the write-rejected output is low.
- R2: A write to offset 0x400 whose bits 31:1 equal bits 31:1 of the key (base plus 0x400) sets the lock state from bit 0 of the data: 1 opens the bank, 0 closes it.
- R3: A write to offset 0x400 whose bits 31:1 differ from the key leaves the lock state unchanged.
- R4: While the bank is open, a write to offset 4*i (i below the pad count) stores the full 32-bit word. The word appears on pad_cfg bits 32*i+31 down to 32*i and reads back at the same offset. This holds for both pad 0 and the last pad.
- R5: While the bank is closed, a write to a pad word or a source-select register is dropped. write_rejected goes high for exactly the one cycle after each such write.
- R6: A read of offset 0x400 returns bits 31:1 of the key, with bit 0 equal to the lock state (1 = open).
- R7: Offsets between the last pad word and 0x400, and unused offsets above the source-select registers, read as zero. Writes to them have no effect and raise no rejection. Address bits 1:0 are ignored.
- R8: With source-select registers enabled, a write while open to 0x404 or 0x408 stores data bits 2:0 into register 0 or 1 respectively. The stored value drives aux_sel bits 3k+2 down to 3k and reads back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte offset within the bank |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| write_rejected | output | 1 | One-cycle pulse after a write dropped by the lock |
| pad_cfg | output | 32*NUM_PADS | All stored pad words, pad i at bits 32*i+31:32*i |
| aux_sel | output | 3*max(AUX_N,1) | Source-select registers, zero when AUX_N is 0 |

## Verification
The hardest situation to reach from the ports is a key write that comes close to valid but is not. One case is a value that matches the key in bit 0 but differs in an upper bit. The other is a correct key sent while the bank is already in the requested state. Either one must leave the lock untouched. The stimulus sends these near-miss keys from both the closed and the open state, then probes the result two ways: by reading the protect register, and by attempting a pad write whose acceptance or rejection shows the true lock state. The last pad word and the first gap offset just above it are also written back to back, which exposes any off-by-one in the pad range decode.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
   localparam int unsigned WORD_W = 32;

   typedef enum logic [1:0] {
      RG_PAD  = 2'd0,
      RG_PROT = 2'd1,
      RG_AUX  = 2'd2,
      RG_NONE = 2'd3
   } region_e;
endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec
   import cfgbank_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NUM_PADS  = 170,
   parameter int unsigned PROT_OFF  = 32'h400,
   parameter int unsigned AUX_N     = 2,
   parameter int unsigned PAD_IDX_W = 8,
   parameter int unsigned AUX_IDX_W = 1
) (
   input  logic [ADDR_W-1:0]    addr,
   output region_e              region,
   output logic [PAD_IDX_W-1:0] pad_idx,
   output logic [AUX_IDX_W-1:0] aux_idx
);
   localparam int unsigned WA_W = ADDR_W - 2;
   localparam logic [WA_W-1:0] PADS_WA = WA_W'(NUM_PADS);
   localparam logic [WA_W-1:0] PROT_WA = WA_W'(PROT_OFF / 4);
   localparam logic [WA_W-1:0] AUX_END = WA_W'(PROT_OFF / 4 + AUX_N);

   logic [WA_W-1:0] wa;
   logic [WA_W-1:0] aux_rel;

   assign wa      = addr[ADDR_W-1:2];
   assign aux_rel = wa - PROT_WA - WA_W'(1);
   assign pad_idx = wa[PAD_IDX_W-1:0];
   assign aux_idx = aux_rel[AUX_IDX_W-1:0];

   always_comb begin
      if (wa < PADS_WA)                       region = RG_PAD;
      else if (wa == PROT_WA)                 region = RG_PROT;
      else if (wa > PROT_WA && wa <= AUX_END) region = RG_AUX;
      else                                    region = RG_NONE;
   end
endmodule

// File: rtl/cfg_key_lock.sv
module cfg_key_lock
   import cfgbank_pkg::*;
#(
   parameter logic [WORD_W-1:0] KEY = 32'h4006_7400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prot_we,
   input  logic [WORD_W-1:0] wdata,
   output logic              is_open,
   output logic [WORD_W-1:0] prot_rd
);
   logic key_ok;

   assign key_ok  = (wdata[WORD_W-1:1] == KEY[WORD_W-1:1]);
   assign prot_rd = {KEY[WORD_W-1:1], is_open};

   always_ff @(posedge clk) begin
      if (!rst_n)                is_open <= 1'b0;
      else if (prot_we && key_ok) is_open <= wdata[0];
   end

   a_r3_bad_key_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_we && (wdata[WORD_W-1:1] != KEY[WORD_W-1:1])) |=> $stable(is_open));

   a_r2_key_sets_state: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_we && (wdata[WORD_W-1:1] == KEY[WORD_W-1:1])) |=> (is_open == $past(wdata[0])));
endmodule

// File: rtl/cfg_word_array.sv
module cfg_word_array
   import cfgbank_pkg::*;
#(
   parameter int unsigned NUM_PADS  = 170,
   parameter int unsigned PAD_IDX_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [PAD_IDX_W-1:0]       idx,
   input  logic [WORD_W-1:0]          wdata,
   output logic [WORD_W-1:0]          rd_word,
   output logic [NUM_PADS*WORD_W-1:0] words
);
   logic [WORD_W-1:0] mem_q [NUM_PADS];

   for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
      always_ff @(posedge clk) begin
         if (!rst_n)
            mem_q[g] <= '0;
         else if (we && idx == PAD_IDX_W'(g))
            mem_q[g] <= wdata;
      end
      assign words[g*WORD_W +: WORD_W] = mem_q[g];
   end

   always_comb begin
      rd_word = '0;
      for (int k = 0; k < NUM_PADS; k++)
         if (idx == PAD_IDX_W'(k)) rd_word = mem_q[k];
   end

   a_r5_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(words));
endmodule

// File: rtl/cfg_aux_regs.sv
module cfg_aux_regs
   import cfgbank_pkg::*;
#(
   parameter int unsigned AUX_N     = 2,
   parameter int unsigned AUX_W     = 3,
   parameter int unsigned AUX_IDX_W = 1,
   parameter int unsigned PORT_W    = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [AUX_IDX_W-1:0] idx,
   input  logic [WORD_W-1:0]    wdata,
   output logic [WORD_W-1:0]    rd_word,
   output logic [PORT_W-1:0]    sel
);
   if (AUX_N > 0) begin : g_aux
      logic [AUX_W-1:0] reg_q [AUX_N];
      for (genvar g = 0; g < AUX_N; g++) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               reg_q[g] <= '0;
            else if (we && idx == AUX_IDX_W'(g))
               reg_q[g] <= wdata[AUX_W-1:0];
         end
         assign sel[g*AUX_W +: AUX_W] = reg_q[g];
      end
      always_comb begin
         rd_word = '0;
         for (int k = 0; k < AUX_N; k++)
            if (idx == AUX_IDX_W'(k)) rd_word = WORD_W'(reg_q[k]);
      end
   end else begin : g_none
      assign sel     = '0;
      assign rd_word = '0;
   end
endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
   import cfgbank_pkg::*;
#(
   parameter int unsigned       NUM_PADS  = 170,
   parameter int unsigned       ADDR_W    = 12,
   parameter int unsigned       PROT_OFF  = 32'h400,
   parameter logic [WORD_W-1:0] BASE_ADDR = 32'h4006_7000,
   parameter int unsigned       AUX_N     = 2,
   parameter int unsigned       AUX_W     = 3,
   localparam int unsigned      AUX_PORT_W = ((AUX_N > 0) ? AUX_N : 1) * AUX_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic                       bus_we,
   input  logic [WORD_W-1:0]          bus_wdata,
   output logic [WORD_W-1:0]          bus_rdata,
   output logic                       write_rejected,
   output logic [NUM_PADS*WORD_W-1:0] pad_cfg,
   output logic [AUX_PORT_W-1:0]      aux_sel
);
   localparam int unsigned       PAD_IDX_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
   localparam int unsigned       AUX_IDX_W = (AUX_N > 1) ? $clog2(AUX_N) : 1;
   localparam logic [WORD_W-1:0] KEY       = BASE_ADDR + WORD_W'(PROT_OFF);

   initial begin
      if (NUM_PADS * 4 > PROT_OFF)
         $error("pad words overlap the protect register");
      if (PROT_OFF + 4 * (AUX_N + 1) > (1 << ADDR_W))
         $error("ADDR_W too narrow for the register layout");
      if (KEY[0] != 1'b0)
         $error("key address must be even");
      if (PROT_OFF % 4 != 0)
         $error("protect offset must be word aligned");
   end

   region_e              region;
   logic [PAD_IDX_W-1:0] pad_idx;
   logic [AUX_IDX_W-1:0] aux_idx;
   logic                 is_open;
   logic [WORD_W-1:0]    prot_rd, pad_rd, aux_rd;
   logic                 gated_hit, pad_we, aux_we, prot_we;

   cfg_addr_dec #(
      .ADDR_W(ADDR_W), .NUM_PADS(NUM_PADS), .PROT_OFF(PROT_OFF),
      .AUX_N(AUX_N), .PAD_IDX_W(PAD_IDX_W), .AUX_IDX_W(AUX_IDX_W)
   ) u_dec (
      .addr(bus_addr), .region(region), .pad_idx(pad_idx), .aux_idx(aux_idx)
   );

   assign prot_we   = bus_we && (region == RG_PROT);
   assign gated_hit = bus_we && (region == RG_PAD || region == RG_AUX);
   assign pad_we    = bus_we && (region == RG_PAD) && is_open;
   assign aux_we    = bus_we && (region == RG_AUX) && is_open;

   cfg_key_lock #(.KEY(KEY)) u_lock (
      .clk(clk), .rst_n(rst_n), .prot_we(prot_we), .wdata(bus_wdata),
      .is_open(is_open), .prot_rd(prot_rd)
   );

   cfg_word_array #(.NUM_PADS(NUM_PADS), .PAD_IDX_W(PAD_IDX_W)) u_words (
      .clk(clk), .rst_n(rst_n), .we(pad_we), .idx(pad_idx), .wdata(bus_wdata),
      .rd_word(pad_rd), .words(pad_cfg)
   );

   cfg_aux_regs #(
      .AUX_N(AUX_N), .AUX_W(AUX_W), .AUX_IDX_W(AUX_IDX_W), .PORT_W(AUX_PORT_W)
   ) u_aux (
      .clk(clk), .rst_n(rst_n), .we(aux_we), .idx(aux_idx), .wdata(bus_wdata),
      .rd_word(aux_rd), .sel(aux_sel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) write_rejected <= 1'b0;
      else        write_rejected <= gated_hit && !is_open;
   end

   always_comb begin
      unique case (region)
         RG_PAD:  bus_rdata = pad_rd;
         RG_PROT: bus_rdata = prot_rd;
         RG_AUX:  bus_rdata = aux_rd;
         default: bus_rdata = '0;
      endcase
   end

   a_r5_locked_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (gated_hit && !is_open) |=> write_rejected);

   a_r5_flag_only_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
      write_rejected |-> $past(bus_we && !is_open));

   a_r5_closed_pads_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !is_open |=> $stable(pad_cfg));

   a_r7_gap_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (region == RG_NONE) |-> (bus_rdata == '0));

   a_r6_prot_read_key: assert property (@(posedge clk) disable iff (!rst_n)
      (region == RG_PROT) |-> (bus_rdata[WORD_W-1:1] == KEY[WORD_W-1:1]));
endmodule

// File: tb/sim_cfgbank_top.sv
module sim_cfgbank_top;
   localparam int unsigned NP   = 170;
   localparam logic [31:0] KEY  = 32'h4006_7400;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [11:0]    bus_addr = '0;
   logic           bus_we = 1'b0;
   logic [31:0]    bus_wdata = '0;
   logic [31:0]    bus_rdata;
   logic           write_rejected;
   logic [NP*32-1:0] pad_cfg;
   logic [5:0]     aux_sel;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   cfgbank_top u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .write_rejected(write_rejected), .pad_cfg(pad_cfg), .aux_sel(aux_sel)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // write: after return, write_rejected reflects that write
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a; bus_we = 1'b0;
      #1 d = bus_rdata;
   endtask

   function automatic logic [31:0] pad(input int i);
      return pad_cfg[i*32 +: 32];
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 reject low", {31'b0, write_rejected}, 32'h0);
      chk("R1 pad0 zero", pad(0), 32'h0);
      chk("R1 pad169 zero", pad(169), 32'h0);
      chk("R1 aux zero", {26'b0, aux_sel}, 32'h0);
      rd(12'h400, v); chk("R1 R6 closed after reset", v, KEY);
   endtask

   task automatic t_locked_write();
      logic [31:0] v;
      wr(12'h010, 32'h0000_0F12);
      chk("R5 reject pulse", {31'b0, write_rejected}, 32'h1);
      @(negedge clk);
      chk("R5 pulse one cycle", {31'b0, write_rejected}, 32'h0);
      chk("R5 pad4 untouched", pad(4), 32'h0);
      rd(12'h010, v); chk("R5 readback zero", v, 32'h0);
   endtask

   task automatic t_bad_key_closed();
      logic [31:0] v;
      wr(12'h400, 32'h4006_7001);
      rd(12'h400, v); chk("R3 wrong key stays closed", v, KEY);
      wr(12'h400, 32'hC006_7401);
      rd(12'h400, v); chk("R3 upper bit off stays closed", v, KEY);
      wr(12'h000, 32'h1);
      chk("R3 pad write still rejected", {31'b0, write_rejected}, 32'h1);
   endtask

   task automatic t_unlock_and_write();
      logic [31:0] v;
      wr(12'h400, KEY | 32'h1);
      rd(12'h400, v); chk("R2 R6 open state", v, KEY | 32'h1);
      wr(12'h000, 32'h0000_0D35);
      chk("R4 no reject when open", {31'b0, write_rejected}, 32'h0);
      chk("R4 pad0 stored", pad(0), 32'h0000_0D35);
      wr(12'h2A4, 32'hDEAD_0C3F);
      chk("R4 last pad stored", pad(169), 32'hDEAD_0C3F);
      rd(12'h2A4, v); chk("R4 last pad readback", v, 32'hDEAD_0C3F);
      wr(12'h01B, 32'hA5A5_5A5A); // low bits ignored -> pad 6
      chk("R7 low addr bits ignored", pad(6), 32'hA5A5_5A5A);
      rd(12'h000, v); chk("R4 pad0 readback", v, 32'h0000_0D35);
   endtask

   task automatic t_gap();
      logic [31:0] v;
      wr(12'h2A8, 32'hFFFF_FFFF);
      chk("R7 gap no reject", {31'b0, write_rejected}, 32'h0);
      rd(12'h2A8, v); chk("R7 gap reads zero", v, 32'h0);
      chk("R7 last pad intact", pad(169), 32'hDEAD_0C3F);
      rd(12'h3FC, v); chk("R7 top of gap zero", v, 32'h0);
      wr(12'h40C, 32'h7);
      rd(12'h40C, v); chk("R7 above aux zero", v, 32'h0);
   endtask

   task automatic t_aux();
      logic [31:0] v;
      wr(12'h404, 32'h5);
      chk("R8 aux0 out", {26'b0, aux_sel}, 32'h5);
      wr(12'h408, 32'hFF);
      chk("R8 aux1 truncated", {26'b0, aux_sel}, 32'h3D);
      rd(12'h408, v); chk("R8 aux1 readback", v, 32'h7);
      rd(12'h404, v); chk("R8 aux0 readback", v, 32'h5);
   endtask

   task automatic t_bad_key_open_and_relock();
      logic [31:0] v;
      wr(12'h400, 32'h4006_7600);
      rd(12'h400, v); chk("R3 wrong key stays open", v, KEY | 32'h1);
      wr(12'h400, KEY | 32'h1);
      rd(12'h400, v); chk("R2 reopen keeps open", v, KEY | 32'h1);
      wr(12'h400, KEY);
      rd(12'h400, v); chk("R2 relock", v, KEY);
      wr(12'h000, 32'h1234_5678);
      chk("R5 reject after relock", {31'b0, write_rejected}, 32'h1);
      chk("R5 pad0 kept", pad(0), 32'h0000_0D35);
      wr(12'h404, 32'h2);
      chk("R5 R8 aux reject", {31'b0, write_rejected}, 32'h1);
      chk("R8 aux kept when closed", {26'b0, aux_sel}, 32'h3D);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_locked_write();
      t_bad_key_closed();
      t_unlock_and_write();
      t_gap();
      t_aux();
      t_bad_key_open_and_relock();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule